// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Format

This block keeps wall-clock time and calendar date as seven packed-BCD bytes: seconds, minutes, hours, day-of-week, day-of-month, month and two-digit year. The year covers 2000 to 2099. A strobe input marks each period of a slow timebase. An internal prescaler counts these strobes and advances the time by one second after a parameterised number of them.

The hours byte describes its own format. One flag bit selects the 12-hour format, and in that format a second flag bit marks PM. The count then runs 12, 1, 2 up to 11 for each half of the day. With the flag clear the hour runs 00 to 23. A parallel write port loads any of the seven bytes. A combinational read port returns any of them. A halt input freezes all counting while it is high.

The block is meant to sit behind a host-facing register interface. That interface supplies the write and read strobes.

Top module: `bcd_calendar`

## Requirements
- R1: After synchronous reset the bytes read back as seconds 0x00, minutes 0x00, hours 0x00 (24-hour format), day-of-week 0x01, day-of-month 0x01, month 0x01, year 0x00.
- R2: Byte addresses are 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day-of-month, 5 month, 6 year. A write stores the full byte, and the read port shows it from the next cycle. A write to address 7 changes nothing, and a read of address 7 returns 0x00.
- R3: With halt low, the time advances by exactly one second on every TICKS_PER_SEC-th accepted strobe. Strobes in between leave all bytes unchanged.
- R4: Seconds and minutes count in BCD from 00 to 59. The step from 59 wraps to 00 and carries into the next field.
- R5: In 24-hour format (hours bit 6 clear) the hour field in bits 5:0 counts BCD 00 to 23. The step from 23 wraps to 00 and advances the date.
- R6: In 12-hour format (hours bit 6 set), bits 4:0 hold BCD 1 to 12 and bit 5 set means PM. The step from 12 goes to 01 with bit 5 unchanged. The step from 11 goes to 12 and inverts bit 5. The date advances only when PM turns into AM. Bits 7 and 6 are kept.
- R7: Day-of-week counts 1 to 7, and the step from 7 wraps to 1 on each date advance.
- R8: Day-of-month wraps to 01 after 28, 29, 30 or 31. February has 29 days when the year value is divisible by 4, and 28 otherwise. April, June, September and November have 30 days, and the other months have 31. The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R9: While halt is high, strobes are ignored: neither the prescaler nor any byte changes, and counting resumes from the same prescaler position.
- R10: A write in the same cycle as a strobe takes effect and the strobe is dropped. Every write restarts the prescaler, so the next second boundary comes TICKS_PER_SEC strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle per sub-second period |
| osc_stop | input | 1 | Active-high halt of all counting |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Byte address for write |
| wr_data | input | 8 | Byte to store |
| rd_addr | input | 3 | Byte address for read |
| rd_data | output | 8 | Byte at rd_addr (combinational) |

## Verification
The hardest case to reach is a chain of carries that runs across every field in one second. Examples are 11:59:59 PM on a Saturday, the last day of a month, in year 99, or the end of February in a leap or non-leap year. Counting to these moments from reset would take years of simulated seconds. The stimulus therefore uses the write port to load a time a few seconds before such a boundary and then supplies strobes. A seeded random loop does the same thing near random boundaries, in both hour formats, with halt and strobe gaps mixed in.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int NUM_REGS    = 7;
    localparam int HR_MODE_BIT = 6;
    localparam int HR_PM_BIT   = 5;

    typedef enum logic [2:0] {
        ADDR_SEC  = 3'd0,
        ADDR_MIN  = 3'd1,
        ADDR_HOUR = 3'd2,
        ADDR_WDAY = 3'd3,
        ADDR_MDAY = 3'd4,
        ADDR_MON  = 3'd5,
        ADDR_YEAR = 3'd6,
        ADDR_NONE = 3'd7
    } cal_addr_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    typedef struct packed {
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_date_t;

    localparam cal_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         wday: 8'h01, mday: 8'h01, mon: 8'h01,
                                         year: 8'h00};

    // Two-digit BCD increment with digit carry
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // 10*t + o is divisible by 4 exactly when 2*t + o is
    function automatic logic leap_year(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic halt,
    input  logic restart,
    output logic sec_strobe
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;
    logic          accept;

    assign accept     = tick && !halt && !restart;
    assign sec_strobe = accept && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (accept)
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end

    // R3: the prescaler never leaves its range
    p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R10: a write restarts the prescaler
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == '0);
    // R9: halt freezes the prescaler
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (halt && !restart) |=> $stable(cnt));
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_pkg::*;
(
    input  logic [7:0] hour_in,
    output logic [7:0] hour_out,
    output logic       day_carry
);
    logic [7:0] inc12;
    logic [7:0] inc24;

    assign inc12 = bcd_inc({3'b000, hour_in[4:0]});
    assign inc24 = bcd_inc({2'b00, hour_in[5:0]});

    always_comb begin
        hour_out  = hour_in;
        day_carry = 1'b0;
        if (hour_in[HR_MODE_BIT]) begin
            case (hour_in[4:0])
                5'h12: hour_out[4:0] = 5'h01;
                5'h11: begin
                    hour_out[4:0]      = 5'h12;
                    hour_out[HR_PM_BIT] = ~hour_in[HR_PM_BIT];
                    day_carry          = hour_in[HR_PM_BIT];
                end
                default: hour_out[4:0] = inc12[4:0];
            endcase
        end else begin
            if (hour_in[5:0] == 6'h23) begin
                hour_out[5:0] = 6'h00;
                day_carry     = 1'b1;
            end else begin
                hour_out[5:0] = inc24[5:0];
            end
        end
    end
endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
    import cal_pkg::*;
(
    input  cal_date_t d_in,
    output cal_date_t d_out
);
    logic [7:0] last_day;

    assign last_day = month_last(d_in.mon, d_in.year);

    always_comb begin
        d_out      = d_in;
        d_out.wday = (d_in.wday >= 8'h07) ? 8'h01 : d_in.wday + 8'h01;
        if (d_in.mday >= last_day) begin
            d_out.mday = 8'h01;
            if (d_in.mon >= 8'h12) begin
                d_out.mon  = 8'h01;
                d_out.year = (d_in.year >= 8'h99) ? 8'h00 : bcd_inc(d_in.year);
            end else begin
                d_out.mon = bcd_inc(d_in.mon);
            end
        end else begin
            d_out.mday = bcd_inc(d_in.mday);
        end
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       osc_stop,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    cal_time_t  t_q;
    cal_time_t  t_next;
    cal_date_t  date_now;
    cal_date_t  date_next;
    logic [7:0] hour_next;
    logic       day_carry;
    logic       sec_strobe;
    logic       sec_wrap;
    logic       min_wrap;

    cal_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .halt       (osc_stop),
        .restart    (wr_en),
        .sec_strobe (sec_strobe)
    );

    cal_hour_step u_hour (
        .hour_in   (t_q.hour),
        .hour_out  (hour_next),
        .day_carry (day_carry)
    );

    assign date_now = '{wday: t_q.wday, mday: t_q.mday, mon: t_q.mon, year: t_q.year};

    cal_date_step u_date (
        .d_in  (date_now),
        .d_out (date_next)
    );

    assign sec_wrap = (t_q.sec == 8'h59);
    assign min_wrap = (t_q.min == 8'h59);

    always_comb begin
        t_next     = t_q;
        t_next.sec = sec_wrap ? 8'h00 : bcd_inc(t_q.sec);
        if (sec_wrap) begin
            t_next.min = min_wrap ? 8'h00 : bcd_inc(t_q.min);
            if (min_wrap) begin
                t_next.hour = hour_next;
                if (day_carry) begin
                    t_next.wday = date_next.wday;
                    t_next.mday = date_next.mday;
                    t_next.mon  = date_next.mon;
                    t_next.year = date_next.year;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= TIME_RESET;
        end else if (wr_en) begin
            case (cal_addr_e'(wr_addr))
                ADDR_SEC:  t_q.sec  <= wr_data;
                ADDR_MIN:  t_q.min  <= wr_data;
                ADDR_HOUR: t_q.hour <= wr_data;
                ADDR_WDAY: t_q.wday <= wr_data;
                ADDR_MDAY: t_q.mday <= wr_data;
                ADDR_MON:  t_q.mon  <= wr_data;
                ADDR_YEAR: t_q.year <= wr_data;
                default:   ;
            endcase
        end else if (sec_strobe) begin
            t_q <= t_next;
        end
    end

    always_comb begin
        case (cal_addr_e'(rd_addr))
            ADDR_SEC:  rd_data = t_q.sec;
            ADDR_MIN:  rd_data = t_q.min;
            ADDR_HOUR: rd_data = t_q.hour;
            ADDR_WDAY: rd_data = t_q.wday;
            ADDR_MDAY: rd_data = t_q.mday;
            ADDR_MON:  rd_data = t_q.mon;
            ADDR_YEAR: rd_data = t_q.year;
            default:   rd_data = 8'h00;
        endcase
    end

    // R10: a write wins over a strobe in the same cycle
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> t_q.sec == $past(wr_data));
    // R2: the unused address does not disturb any byte
    p_addr7_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd7) |=> $stable(t_q));
    // R9: halt freezes the time when no write is present
    p_halt_time_r9: assert property (@(posedge clk) disable iff (rst)
        (osc_stop && !wr_en) |=> $stable(t_q));
    // R6: 11:59:59 AM in 12-hour format turns into 12 PM without a date step
    p_noon_r6: assert property (@(posedge clk) disable iff (rst)
        (sec_strobe && !wr_en && t_q.sec == 8'h59 && t_q.min == 8'h59 && t_q.hour == 8'h51)
        |=> (t_q.hour == 8'h72 && $stable(t_q.mday)));
    // R4: the seconds byte moves only through a write or a one-second step
    p_sec_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !sec_strobe) |=> $stable(t_q));
endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/100ps
module sim_bcd_calendar;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       osc_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m [7];
    int pc;

    bcd_calendar #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .osc_stop(osc_stop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic int bcd2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2bcd(input int i);
        return 8'(((i / 10) << 4) | (i % 10));
    endfunction

    function automatic int days_of(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_enc(input int h24, input bit fmt12);
        int v;
        if (!fmt12) return i2bcd(h24);
        v = h24 % 12;
        if (v == 0) v = 12;
        return 8'h40 | ((h24 >= 12) ? 8'h20 : 8'h00) | i2bcd(v);
    endfunction

    task automatic model_second();
        int s, mi, h, d, mo, y;
        bit fmt12;
        s = bcd2i(m[0]) + 1;
        if (s < 60) begin m[0] = i2bcd(s); return; end
        m[0] = 8'h00;
        mi = bcd2i(m[1]) + 1;
        if (mi < 60) begin m[1] = i2bcd(mi); return; end
        m[1] = 8'h00;
        fmt12 = m[2][6];
        if (fmt12) h = (bcd2i(m[2] & 8'h1f) % 12) + (m[2][5] ? 12 : 0);
        else       h = bcd2i(m[2] & 8'h3f);
        h++;
        m[2] = (m[2] & 8'h80) | hour_enc(h % 24, fmt12);
        if (h < 24) return;
        m[3] = (m[3] >= 8'h07) ? 8'h01 : m[3] + 8'h01;
        d = bcd2i(m[4]) + 1; mo = bcd2i(m[5]); y = bcd2i(m[6]);
        if (d > days_of(mo, y)) begin
            d = 1; mo++;
            if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
        end
        m[4] = i2bcd(d); m[5] = i2bcd(mo); m[6] = i2bcd(y);
    endtask

    task automatic cyc(input logic t, input logic st, input logic we,
                       input logic [2:0] wa, input logic [7:0] wd);
        @(negedge clk);
        tick = t; osc_stop = st; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        if (we) begin
            if (wa < 3'd7) m[wa] = wd;
            pc = 0;
        end else if (t && !st) begin
            if (pc == TPS - 1) begin pc = 0; model_second(); end
            else pc++;
        end
        #1;
        tick = 1'b0; wr_en = 1'b0; osc_stop = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] exp;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.3;
            exp = (a < 7) ? m[a] : 8'h00;
            n_tests++;
            if (rd_data !== exp) begin
                n_fail++;
                $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, exp);
            end
        end
    endtask

    task automatic expect_reg(input int a, input logic [7:0] val, input string tag);
        rd_addr = 3'(a);
        #0.3;
        n_tests++;
        if (rd_data !== val) begin
            n_fail++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, val);
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] wd, input logic [7:0] d,
                            input logic [7:0] mo, input logic [7:0] y);
        cyc(0, 0, 1, 3'd0, s);  cyc(0, 0, 1, 3'd1, mi); cyc(0, 0, 1, 3'd2, h);
        cyc(0, 0, 1, 3'd3, wd); cyc(0, 0, 1, 3'd4, d);  cyc(0, 0, 1, 3'd5, mo);
        cyc(0, 0, 1, 3'd6, y);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 3'd0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240607);
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check_all("R1 reset");
        expect_reg(3, 8'h01, "R1 wday reset");

        // R2: each address and the ignored address 7
        set_time(8'h12, 8'h34, 8'h15, 8'h04, 8'h21, 8'h06, 8'h37);
        check_all("R2 write readback");
        cyc(0, 0, 1, 3'd7, 8'hAA);
        check_all("R2 addr7 ignored");

        // R3: prescaler divides strobes
        set_time(8'h10, 8'h00, 8'h08, 8'h02, 8'h10, 8'h03, 8'h20);
        ticks(TPS - 1);
        expect_reg(0, 8'h10, "R3 before boundary");
        ticks(1);
        expect_reg(0, 8'h11, "R3 at boundary");
        check_all("R3");

        // R4: minute and hour carry
        set_time(8'h59, 8'h59, 8'h10, 8'h02, 8'h10, 8'h03, 8'h20);
        ticks(TPS);
        expect_reg(2, 8'h11, "R4 hour carry");
        expect_reg(1, 8'h00, "R4 min wrap");
        check_all("R4");

        // R5 R7 R8: full carry chain at year end
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        ticks(TPS);
        expect_reg(2, 8'h00, "R5 hour wrap");
        expect_reg(3, 8'h01, "R7 wday wrap");
        expect_reg(6, 8'h00, "R8 year wrap");
        check_all("R5 R7 R8 new year");

        // R6: 12-hour corners
        set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h14, 8'h05, 8'h22);
        ticks(TPS);
        expect_reg(2, 8'h72, "R6 noon");
        expect_reg(4, 8'h14, "R6 no date step at noon");
        set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h14, 8'h05, 8'h22);
        ticks(TPS);
        expect_reg(2, 8'h52, "R6 midnight");
        expect_reg(4, 8'h15, "R6 date step at midnight");
        set_time(8'h59, 8'h59, 8'h52, 8'h03, 8'h14, 8'h05, 8'h22);
        ticks(TPS);
        expect_reg(2, 8'h41, "R6 12 to 1 AM");
        check_all("R6");

        // R8: month lengths and leap years
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        ticks(TPS);
        expect_reg(4, 8'h29, "R8 leap feb 29");
        ticks(TPS * 86400 / 86400 - TPS);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
        ticks(TPS);
        expect_reg(5, 8'h03, "R8 leap to march");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        ticks(TPS);
        expect_reg(4, 8'h01, "R8 common feb end");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
        ticks(TPS);
        expect_reg(5, 8'h05, "R8 april end");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23);
        ticks(TPS);
        expect_reg(4, 8'h31, "R8 jan 31 exists");
        check_all("R8");

        // R9: halt holds time and prescaler position
        set_time(8'h20, 8'h00, 8'h08, 8'h02, 8'h10, 8'h03, 8'h20);
        ticks(2);
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 3'd0, 8'h00);
        expect_reg(0, 8'h20, "R9 halted");
        ticks(2);
        expect_reg(0, 8'h21, "R9 resumes position");
        check_all("R9");

        // R10: write beats strobe and restarts the prescaler
        ticks(TPS - 1);
        cyc(1, 0, 1, 3'd0, 8'h40);
        expect_reg(0, 8'h40, "R10 write wins");
        ticks(TPS - 1);
        expect_reg(0, 8'h40, "R10 prescaler restarted");
        ticks(1);
        expect_reg(0, 8'h41, "R10 next boundary");

        // random near-boundary runs
        for (int it = 0; it < 30; it++) begin
            int mo, y, dd, h24;
            bit f12;
            mo  = 1 + int'($urandom % 12);
            y   = int'($urandom % 100);
            dd  = ($urandom % 2) ? days_of(mo, y) : 1 + int'($urandom % days_of(mo, y));
            h24 = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : int'($urandom % 24);
            f12 = bit'($urandom % 2);
            set_time(i2bcd(55 + int'($urandom % 5)),
                     ($urandom % 2) ? 8'h59 : i2bcd(int'($urandom % 60)),
                     hour_enc(h24, f12), i2bcd(1 + int'($urandom % 7)),
                     i2bcd(dd), i2bcd(mo), i2bcd(y));
            for (int k = 0; k < 40; k++) begin
                if ($urandom % 20 == 0)
                    cyc(bit'($urandom % 2), 0, 1, 3'd0, i2bcd(50 + int'($urandom % 10)));
                else
                    cyc(($urandom % 4) != 0, ($urandom % 8) == 0, 0, 3'd0, 8'h00);
                check_all("R3 R4 R5 R6 R7 R8 R9 R10 random");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule